// File: doc/BRIEF.md
# Multiplexed LCD Common and Segment Sequencer

This block produces the drive-level codes for a multiplexed liquid-crystal panel that has up to four common lines and `NUM_SEG` segment lines. It runs from a 32.768 kHz base clock. It steps through the time slots of the active commons and inverts the drive polarity at the end of every frame. For each segment it turns the on/off bit of the current slot into a 2-bit level code. An analog stage outside the block converts these codes into panel voltages. Software selects one of six drive schemes on `mode_sel`: static, half bias with 1/2, 1/3 or 1/4 duty, and third bias with 1/3 or 1/4 duty.

Each segment is either an LCD drive or a general-purpose output, as set by `seg_lcd`. A small state machine sequences the block. It has three states. ST_HOLD is the state during reset, with every output off. ST_BLANK lasts one frame after reset: the commons are driven and every LCD segment is unlit. ST_RUN is normal operation. The transitions are: reset enters ST_HOLD, ST_HOLD goes to ST_BLANK on the first clock after reset, ST_BLANK goes to ST_RUN at the end of a frame, and ST_RUN stays in ST_RUN.

Top module: `lcd_mux_seq`

## Requirements
- R1: While `rst_n` is low, `com_act` is 0 and every bit of `com_lvl` and `seg_lvl` is 0.
- R2: `mode_sel` selects the scheme. 0 is static with one common and half-bias levels. 1, 2 and 3 are half bias with 2, 3 and 4 commons. 4 and 5 are third bias with 3 and 4 commons. Codes 6 and 7 act as static. The active commons are the lowest-numbered ones, so `com_act` shows 0001, 0011, 0111 or 1111.
- R3: With the default parameters, a slot lasts 1024 cycles in static mode, 512 with two commons and 256 with four commons. With three commons it lasts 256 cycles, which gives a 768-cycle frame.
- R4: Level codes are 00 zero, 01 lower intermediate, 10 upper intermediate and 11 full. Common c occupies `com_lvl[2c+1:2c]`. In slot c, common c drives the select level: 11 in positive polarity, 00 in negative polarity. An active common that is not selected drives 01 under half bias. Under third bias it drives 01 in positive polarity and 10 in negative polarity.
- R5: Polarity starts positive when ST_BLANK is entered and inverts at the end of every frame.
- R6: In ST_RUN, an LCD segment whose bit `seg_on[slot*NUM_SEG+i]` is 1 drives the level opposite to the select level: 00 in positive polarity, 11 in negative polarity.
- R7: An unlit LCD segment drives the select level under half bias or static. Under third bias it drives 10 in positive polarity and 01 in negative polarity.
- R8: In ST_RUN, a segment with `seg_lcd[i]`=0 drives 11 when `seg_gpo[i]` is 1 and 00 otherwise.
- R9: During the first frame after reset, every LCD segment drives the unlit level and every general-purpose segment drives 00.
- R10: A new `mode_sel` value is taken only at a frame boundary. A change in the middle of a frame leaves `com_act` and the slot timing unchanged until that frame ends.
- R11: An inactive common drives 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Drive scheme code, taken at frame boundaries |
| seg_lcd | input | NUM_SEG | 1 = LCD drive, 0 = general-purpose output, per segment |
| seg_gpo | input | NUM_SEG | Value for general-purpose segments |
| seg_on | input | 4*NUM_SEG | Per-slot on bits, slot s at [s*NUM_SEG +: NUM_SEG] |
| com_act | output | 4 | Common c is being driven |
| com_lvl | output | 8 | 2-bit level code per common |
| seg_lvl | output | 2*NUM_SEG | 2-bit level code per segment |

## Verification
The bench measures how long a common holds its select level in static, two-common, three-common and four-common modes. A slot length derived from the wrong frame period shows up there as a run of the wrong length. It changes `mode_sel` in the middle of a frame and expects `com_act` to stay unchanged; a design that takes the new mode at once would switch commons part-way through a frame. The bench also checks the blank frame after both the initial reset and a reset in the middle of a run. A design that drives the lit level early, or forgets to invert polarity, would produce segment codes with the wrong polarity. Codes 6 and 7 are applied to confirm that they fall back to static.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_BLANK = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [2:0] ncom;
        logic       third_bias;
    } drive_cfg_t;

    localparam logic [1:0] LVL_ZERO = 2'b00;
    localparam logic [1:0] LVL_LOW  = 2'b01;
    localparam logic [1:0] LVL_UP   = 2'b10;
    localparam logic [1:0] LVL_FULL = 2'b11;

    function automatic drive_cfg_t decode_mode(input logic [2:0] code);
        drive_cfg_t cfg;
        case (code)
            3'd1:    begin cfg.ncom = 3'd2; cfg.third_bias = 1'b0; end
            3'd2:    begin cfg.ncom = 3'd3; cfg.third_bias = 1'b0; end
            3'd3:    begin cfg.ncom = 3'd4; cfg.third_bias = 1'b0; end
            3'd4:    begin cfg.ncom = 3'd3; cfg.third_bias = 1'b1; end
            3'd5:    begin cfg.ncom = 3'd4; cfg.third_bias = 1'b1; end
            default: begin cfg.ncom = 3'd1; cfg.third_bias = 1'b0; end
        endcase
        return cfg;
    endfunction

endpackage

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer
    import lcd_seq_pkg::*;
#(
    parameter int FRAME_LEN     = 1024,
    parameter int FRAME_LEN_TRI = 768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] mode_in,
    output drive_cfg_t cfg_q,
    output logic [1:0] slot_q,
    output logic       pol_q,
    output logic       frame_end
);

    localparam int CW = $clog2(FRAME_LEN);
    localparam logic [CW:0] LEN_ONE   = (CW+1)'(FRAME_LEN);
    localparam logic [CW:0] LEN_TWO   = (CW+1)'(FRAME_LEN / 2);
    localparam logic [CW:0] LEN_THREE = (CW+1)'(FRAME_LEN_TRI / 3);
    localparam logic [CW:0] LEN_FOUR  = (CW+1)'(FRAME_LEN / 4);

    logic [CW-1:0] cnt_q;
    logic [CW:0]   slot_len;
    logic          slot_last;
    logic          com_last;

    always_comb begin
        case (cfg_q.ncom)
            3'd1:    slot_len = LEN_ONE;
            3'd2:    slot_len = LEN_TWO;
            3'd3:    slot_len = LEN_THREE;
            default: slot_len = LEN_FOUR;
        endcase
        slot_last = ({1'b0, cnt_q} == slot_len - 1'b1);
        com_last  = ({1'b0, slot_q} == cfg_q.ncom - 3'd1);
        frame_end = run && slot_last && com_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            slot_q <= '0;
            pol_q  <= 1'b0;
            cfg_q  <= decode_mode(3'd0);
        end else if (!run) begin
            cnt_q  <= '0;
            slot_q <= '0;
            pol_q  <= 1'b0;
            cfg_q  <= decode_mode(mode_in);
        end else if (slot_last) begin
            cnt_q <= '0;
            if (com_last) begin
                slot_q <= '0;
                pol_q  <= ~pol_q;
                cfg_q  <= decode_mode(mode_in);
            end else begin
                slot_q <= slot_q + 2'd1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG = 8
) (
    input  seq_state_t               state,
    input  drive_cfg_t               cfg,
    input  logic [1:0]               slot,
    input  logic                     pol,
    input  logic [NUM_SEG-1:0]       seg_lcd,
    input  logic [NUM_SEG-1:0]       seg_gpo,
    input  logic [4*NUM_SEG-1:0]     seg_on,
    output logic [3:0]               com_act,
    output logic [7:0]               com_lvl,
    output logic [2*NUM_SEG-1:0]     seg_lvl
);

    logic               drive;
    logic               live;
    logic [1:0]         sel_lvl;
    logic [1:0]         opp_lvl;
    logic [1:0]         com_idle_lvl;
    logic [1:0]         seg_dark_lvl;
    logic [NUM_SEG-1:0] row;

    always_comb begin
        drive        = (state != ST_HOLD);
        live         = (state == ST_RUN);
        sel_lvl      = pol ? LVL_ZERO : LVL_FULL;
        opp_lvl      = pol ? LVL_FULL : LVL_ZERO;
        com_idle_lvl = cfg.third_bias ? (pol ? LVL_UP : LVL_LOW) : LVL_LOW;
        seg_dark_lvl = cfg.third_bias ? (pol ? LVL_LOW : LVL_UP) : sel_lvl;
        case (slot)
            2'd0:    row = seg_on[0*NUM_SEG +: NUM_SEG];
            2'd1:    row = seg_on[1*NUM_SEG +: NUM_SEG];
            2'd2:    row = seg_on[2*NUM_SEG +: NUM_SEG];
            default: row = seg_on[3*NUM_SEG +: NUM_SEG];
        endcase
    end

    for (genvar c = 0; c < 4; c++) begin : g_com
        always_comb begin
            com_act[c] = drive && (3'(c) < cfg.ncom);
            if (!com_act[c])
                com_lvl[2*c +: 2] = LVL_ZERO;
            else if (slot == 2'(c))
                com_lvl[2*c +: 2] = sel_lvl;
            else
                com_lvl[2*c +: 2] = com_idle_lvl;
        end
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        always_comb begin
            if (!drive)
                seg_lvl[2*s +: 2] = LVL_ZERO;
            else if (!seg_lcd[s])
                seg_lvl[2*s +: 2] = (live && seg_gpo[s]) ? LVL_FULL : LVL_ZERO;
            else if (live && row[s])
                seg_lvl[2*s +: 2] = opp_lvl;
            else
                seg_lvl[2*s +: 2] = seg_dark_lvl;
        end
    end

endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG       = 8,
    parameter int FRAME_LEN     = 1024,
    parameter int FRAME_LEN_TRI = 768
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             mode_sel,
    input  logic [NUM_SEG-1:0]     seg_lcd,
    input  logic [NUM_SEG-1:0]     seg_gpo,
    input  logic [4*NUM_SEG-1:0]   seg_on,
    output logic [3:0]             com_act,
    output logic [7:0]             com_lvl,
    output logic [2*NUM_SEG-1:0]   seg_lvl
);

    seq_state_t state_q;
    seq_state_t state_d;
    drive_cfg_t cfg_q;
    logic [1:0] slot_q;
    logic       pol_q;
    logic       frame_end;
    logic       run;

    assign run = (state_q != ST_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HOLD;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = ST_BLANK;
            ST_BLANK: if (frame_end) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_HOLD;
        endcase
    end

    lcd_slot_timer #(
        .FRAME_LEN     (FRAME_LEN),
        .FRAME_LEN_TRI (FRAME_LEN_TRI)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .mode_in   (mode_sel),
        .cfg_q     (cfg_q),
        .slot_q    (slot_q),
        .pol_q     (pol_q),
        .frame_end (frame_end)
    );

    lcd_level_map #(
        .NUM_SEG (NUM_SEG)
    ) u_map (
        .state   (state_q),
        .cfg     (cfg_q),
        .slot    (slot_q),
        .pol     (pol_q),
        .seg_lcd (seg_lcd),
        .seg_gpo (seg_gpo),
        .seg_on  (seg_on),
        .com_act (com_act),
        .com_lvl (com_lvl),
        .seg_lvl (seg_lvl)
    );

endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
    parameter int NUM_SEG = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [3:0]           com_act,
    input logic [7:0]           com_lvl,
    input logic [2*NUM_SEG-1:0] seg_lvl,
    input logic                 frame_end
);

    logic [3:0] extreme;

    always_comb begin
        for (int c = 0; c < 4; c++)
            extreme[c] = com_act[c] &&
                         (com_lvl[2*c +: 2] == 2'b00 || com_lvl[2*c +: 2] == 2'b11);
    end

    // R1
    reset_off_chk: assert property (@(posedge clk)
        !rst_n |-> (com_act == 4'd0 && com_lvl == 8'd0 && seg_lvl == '0));

    // R2
    com_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (com_act != 4'd0) |->
        (com_act == 4'b0001 || com_act == 4'b0011 ||
         com_act == 4'b0111 || com_act == 4'b1111));

    // R11
    idle_com_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (com_act[0] || com_lvl[1:0] == 2'b00) &&
        (com_act[1] || com_lvl[3:2] == 2'b00) &&
        (com_act[2] || com_lvl[5:4] == 2'b00) &&
        (com_act[3] || com_lvl[7:6] == 2'b00));

    // R4
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (com_act != 4'd0) |-> ($countones(extreme) == 1));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(com_act) != 4'd0 && !$past(frame_end)) |-> $stable(com_act));

endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .com_act   (com_act),
    .com_lvl   (com_lvl),
    .seg_lvl   (seg_lvl),
    .frame_end (frame_end)
);

// File: tb/lcd_mux_seq_tb.sv
module lcd_mux_seq_tb;

    localparam int NS = 8;
    localparam int FL = 1024;
    localparam int FLT = 768;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      mode_sel = 3'd0;
    logic [NS-1:0]   seg_lcd = '0;
    logic [NS-1:0]   seg_gpo = '0;
    logic [4*NS-1:0] seg_on = '0;
    logic [3:0]      com_act;
    logic [7:0]      com_lvl;
    logic [2*NS-1:0] seg_lvl;

    int checks = 0;
    int errors = 0;

    // reference model: 0 hold, 1 blank, 2 run
    int m_state = 0;
    int m_cnt = 0;
    int m_slot = 0;
    int m_pol = 0;
    int m_ncom = 1;
    int m_b3 = 0;

    always #5 clk = ~clk;

    lcd_mux_seq #(.NUM_SEG(NS), .FRAME_LEN(FL), .FRAME_LEN_TRI(FLT)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .seg_lcd(seg_lcd),
        .seg_gpo(seg_gpo), .seg_on(seg_on), .com_act(com_act),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    function automatic int ncom_of(input int m);
        case (m)
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 3;
            5: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic int b3_of(input int m);
        return (m == 4 || m == 5) ? 1 : 0;
    endfunction

    function automatic int slen(input int n);
        case (n)
            1: return FL;
            2: return FL / 2;
            3: return FLT / 3;
            default: return FL / 4;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_slot = 0; m_pol = 0; m_ncom = 1; m_b3 = 0;
        end else if (m_state == 0) begin
            m_state = 1; m_cnt = 0; m_slot = 0; m_pol = 0;
            m_ncom = ncom_of(int'(mode_sel)); m_b3 = b3_of(int'(mode_sel));
        end else if (m_cnt == slen(m_ncom) - 1) begin
            m_cnt = 0;
            if (m_slot == m_ncom - 1) begin
                m_slot = 0;
                m_pol = 1 - m_pol;
                m_ncom = ncom_of(int'(mode_sel));
                m_b3 = b3_of(int'(mode_sel));
                if (m_state == 1) m_state = 2;
            end else begin
                m_slot++;
            end
        end else begin
            m_cnt++;
        end
    end

    function automatic logic [3:0] e_act();
        logic [3:0] e;
        for (int i = 0; i < 4; i++) e[i] = (m_state != 0) && (i < m_ncom);
        return e;
    endfunction

    function automatic logic [7:0] e_com();
        logic [7:0] e;
        for (int i = 0; i < 4; i++) begin
            if (m_state == 0 || i >= m_ncom) e[2*i +: 2] = 2'b00;
            else if (i == m_slot) e[2*i +: 2] = (m_pol != 0) ? 2'b00 : 2'b11;
            else if (m_b3 != 0) e[2*i +: 2] = (m_pol != 0) ? 2'b10 : 2'b01;
            else e[2*i +: 2] = 2'b01;
        end
        return e;
    endfunction

    function automatic logic [2*NS-1:0] e_seg();
        logic [2*NS-1:0] e;
        logic [1:0] hi;
        hi = (m_pol != 0) ? 2'b00 : 2'b11;
        for (int i = 0; i < NS; i++) begin
            if (m_state == 0) e[2*i +: 2] = 2'b00;
            else if (!seg_lcd[i]) e[2*i +: 2] = (m_state == 2 && seg_gpo[i]) ? 2'b11 : 2'b00;
            else if (m_state == 2 && seg_on[m_slot*NS + i]) e[2*i +: 2] = ~hi;
            else if (m_b3 != 0) e[2*i +: 2] = (m_pol != 0) ? 2'b01 : 2'b10;
            else e[2*i +: 2] = hi;
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        logic [3:0] ea;
        logic [7:0] ec;
        logic [2*NS-1:0] es;
        ea = e_act(); ec = e_com(); es = e_seg();
        chk(com_act == ea, (m_state == 0) ? "R1 com_act" : "R2 com_act", 64'(com_act), 64'(ea));
        chk(com_lvl == ec, (m_state == 0) ? "R1 com_lvl" : "R4 R5 R11 com_lvl", 64'(com_lvl), 64'(ec));
        chk(seg_lvl == es, (m_state == 0) ? "R1 seg_lvl" :
                           (m_state == 1) ? "R9 seg_lvl" : "R6 R7 R8 seg_lvl",
            64'(seg_lvl), 64'(es));
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic shuffle_segs();
        seg_on  = {$urandom, $urandom};
        seg_lcd = NS'($urandom) | NS'($urandom);
        seg_gpo = NS'($urandom);
    endtask

    // R3: length of a run at select level on common 0
    task automatic measure(input int mode, input int exp_len);
        logic [1:0] prev;
        logic [1:0] v;
        int run_len;
        mode_sel = 3'(mode);
        repeat (2 * FL + 8) step();
        prev = com_lvl[1:0];
        step();
        while (!(com_lvl[1:0] != prev && (com_lvl[1:0] == 2'b00 || com_lvl[1:0] == 2'b11))) begin
            prev = com_lvl[1:0];
            step();
        end
        v = com_lvl[1:0];
        run_len = 1;
        step();
        while (com_lvl[1:0] == v) begin
            run_len++;
            step();
        end
        chk(run_len == exp_len, "R3 slot length", 64'(run_len), 64'(exp_len));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        seg_lcd = 8'hF0;
        seg_gpo = 8'hFF;
        seg_on  = 32'hA5A5_5A5A;
        mode_sel = 3'd5;
        repeat (3) step();             // R1 reset state
        rst_n = 1'b1;
        repeat (FL + 20) step();       // R9 blank frame then run

        measure(0, FL);                // R3 static
        measure(1, FL / 2);            // R3 two commons
        measure(4, FLT / 3);           // R3 three commons
        measure(3, FL / 4);            // R3 four commons

        // R10: mid-frame change keeps four commons until frame end
        mode_sel = 3'd5;
        repeat (2 * FL) step();
        while (m_cnt != 10) step();
        mode_sel = 3'd0;
        step();
        chk(com_act == 4'b1111, "R10 mode held mid-frame", 64'(com_act), 64'hF);
        repeat (FL + 8) step();
        chk(com_act == 4'b0001, "R10 mode applied at boundary", 64'(com_act), 64'h1);

        // R2: unused codes fall back to static
        mode_sel = 3'd7;
        repeat (2 * FL + 8) step();
        chk(com_act == 4'b0001, "R2 code 7 static", 64'(com_act), 64'h1);
        mode_sel = 3'd6;
        repeat (2 * FL + 8) step();
        chk(com_act == 4'b0001, "R2 code 6 static", 64'(com_act), 64'h1);

        // random phase
        for (int it = 0; it < 30000; it++) begin
            step();
            if ($urandom % 64 == 0) shuffle_segs();
            if ($urandom % 1500 == 0) mode_sel = 3'($urandom % 8);
        end

        // mid-run reset, then blank frame again (R1, R9)
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        mode_sel = 3'd2;
        shuffle_segs();
        for (int it = 0; it < 6000; it++) begin
            step();
            if ($urandom % 128 == 0) shuffle_segs();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule